// File: doc/BRIEF.md
# Radio Transceiver SPI Command Engine

This block is an SPI master that runs whole command transactions against a packet radio transceiver. A host loads an operation code, an address or register index, a write length and a read limit. It then pulses a start strobe. The engine frames the transaction for that operation: chip-select, command byte, any address or length byte, then the data phase. It ends the frame and pulses a done flag.

Write data comes in through a valid/ready byte stream. If the stream has no byte ready, the serial clock stays low until one arrives. Read data leaves through a valid-only byte stream. The number of bytes read is reported when the transaction ends.

For a buffer read, the transceiver first returns a length byte L. L+1 bytes follow it, the last one being a link quality byte. The engine reads that count, clipped to the host's limit. The length byte itself is consumed by the engine and is not forwarded. The command codes, the register index mask and the serial clock half-period are parameters.

Top module: `rf_spi_engine`

## Requirements
- R1: Chip-select is high while the engine is idle. It falls once per accepted transaction, stays low across every byte of that transaction, and is high again in the cycle that done is reported. The serial clock never pulses while chip-select is high.
- R2: Bytes shift most significant bit first. Data-out changes only while the serial clock is low, and the serial clock idles low.
- R3: Data-in is sampled at the end of each low phase, before the rising edge. A slave that updates its output just after each rising edge is read correctly.
- R4: Register access. Op 0 is a write and op 1 is a read. The command byte is the write code (default 0xC0) or the read code (default 0x80), ORed with the index masked by the index mask (default 0x3F). A write then sends one byte taken from the write stream. A read then clocks out 0x00, delivers the received byte on the read stream, and reports read length 1.
- R5: Buffer write (op 2) sends the code (default 0x60), then the write length N, then exactly N bytes from the write stream. With N = 0 the frame ends after the length byte.
- R6: Buffer read (op 3) sends the code (default 0x20) and receives a length byte L, which is not forwarded. It then reads min(L+1, read limit) bytes, clocking out 0x00 for each, and forwards each byte. The read length output reports that count, which is 0 when the limit is 0.
- R7: SRAM access. Op 4 is a write (default code 0x40) and op 5 is a read (default code 0x00). The engine sends the code, then the address byte. A write then sends one stream byte. A read then clocks out 0x00 and forwards one received byte with read length 1.
- R8: A start strobe is ignored while busy, as are op codes 6 and 7. Operation, address, lengths and framing stay those of the running transaction.
- R9: While the engine waits for a write-stream byte (ready high, valid low), the serial clock stays low and no bit is shifted.
- R10: Each serial clock high phase, and each low phase within a byte, lasts exactly HALF_DIV clock cycles.
- R11: Done is a one-cycle pulse. Busy is low in that same cycle, and the read length is valid from that cycle until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| op_i | input | 3 | Operation code 0..5 |
| addr_i | input | 8 | Register index or SRAM address |
| wr_len_i | input | 8 | Buffer write byte count |
| rd_max_i | input | 8 | Buffer read byte limit |
| wr_valid_i | input | 1 | Write stream byte valid |
| wr_data_i | input | 8 | Write stream byte |
| wr_ready_o | output | 1 | Write stream byte accepted this cycle if valid |
| rd_valid_o | output | 1 | Read stream byte valid (one cycle) |
| rd_data_o | output | 8 | Read stream byte |
| rd_len_o | output | 8 | Bytes read by the last transaction |
| done_o | output | 1 | Transaction complete pulse |
| busy_o | output | 1 | Transaction in progress |
| spi_csn_o | output | 1 | Chip-select, active low |
| spi_sck_o | output | 1 | Serial clock, idle low |
| spi_mosi_o | output | 1 | Serial data to the transceiver |
| spi_miso_i | input | 1 | Serial data from the transceiver |

## Verification
The bench targets the buffer read count at its edges: a length below the limit, a clipped length, L = 255 with limit 255, and limit 0. An off-by-one in the quality-byte addition or in the clip would deliver one byte too many or too few. It would also leave chip-select low too long and report the wrong read length.

The bench also checks the register index mask with an index whose upper bits are set. If the mask were missing, those bits would corrupt the command byte.

Writes are run with stream stalls to show that the clock is held and no bit is shifted early. A second start is fired mid-transaction; an engine that accepted it would append or alter bytes. Sampling on the wrong side of the rising edge would shift every received byte by one bit.

// File: rtl/rf_spi_pkg.sv
package rf_spi_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    OP_REG_WR  = 3'd0,
    OP_REG_RD  = 3'd1,
    OP_BUF_WR  = 3'd2,
    OP_BUF_RD  = 3'd3,
    OP_SRAM_WR = 3'd4,
    OP_SRAM_RD = 3'd5
  } op_e;

  // kind of the next byte on the wire
  typedef enum logic [2:0] {
    K_CMD   = 3'd0,
    K_ADDR  = 3'd1,
    K_LEN   = 3'd2,
    K_RLEN  = 3'd3,
    K_WDATA = 3'd4,
    K_RDATA = 3'd5
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_SEL  = 3'd1,
    S_LOAD = 3'd2,
    S_XFER = 3'd3,
    S_END  = 3'd4
  } seq_st_e;
endpackage

// File: rtl/rf_spi_tick.sv
module rf_spi_tick #(
  parameter int unsigned HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rf_spi_shifter.sv
module rf_spi_shifter
  import rf_spi_pkg::*;
#(
  parameter int unsigned HALF = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  go_i,
  input  byte_t tx_i,
  input  logic  miso_i,
  output logic  sck_o,
  output logic  mosi_o,
  output logic  busy_o,
  output logic  done_o,
  output byte_t rx_o
);
  logic       active_q, sck_q, done_q, tick;
  logic [2:0] bit_q;
  byte_t      sh_q, rx_q;

  rf_spi_tick #(.HALF(HALF)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (active_q),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      done_q   <= 1'b0;
      bit_q    <= '0;
      sh_q     <= '0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i && !active_q) begin
        active_q <= 1'b1;
        sh_q     <= tx_i;
        bit_q    <= '0;
        sck_q    <= 1'b0;
      end else if (active_q && tick) begin
        if (!sck_q) begin
          // sample at end of low phase, before the rising edge
          rx_q  <= {rx_q[BYTE_W-2:0], miso_i};
          sck_q <= 1'b1;
        end else begin
          sck_q <= 1'b0;
          if (bit_q == 3'd7) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
            sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = active_q ? sh_q[BYTE_W-1] : 1'b0;
  assign busy_o = active_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;

  logic [15:0] hi_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hi_cnt_q <= '0;
    else if (sck_q) hi_cnt_q <= hi_cnt_q + 16'd1;
    else            hi_cnt_q <= '0;
  end

  p_mosi_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_q && $past(sck_q)) |-> $stable(mosi_o));

  p_sck_width_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_q |-> (hi_cnt_q < 16'(HALF)));
endmodule

// File: rtl/rf_cmd_seq.sv
module rf_cmd_seq
  import rf_spi_pkg::*;
#(
  parameter byte_t CMD_REG_WR   = 8'hC0,
  parameter byte_t CMD_REG_RD   = 8'h80,
  parameter byte_t CMD_BUF_WR   = 8'h60,
  parameter byte_t CMD_BUF_RD   = 8'h20,
  parameter byte_t CMD_SRAM_WR  = 8'h40,
  parameter byte_t CMD_SRAM_RD  = 8'h00,
  parameter byte_t REG_IDX_MASK = 8'h3F
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [2:0] op_i,
  input  byte_t      addr_i,
  input  byte_t      wr_len_i,
  input  byte_t      rd_max_i,
  input  logic       wr_valid_i,
  input  byte_t      wr_data_i,
  output logic       wr_ready_o,
  output logic       rd_valid_o,
  output byte_t      rd_data_o,
  output byte_t      rd_len_o,
  output logic       done_o,
  output logic       busy_o,
  output logic       csn_o,
  output logic       sh_go_o,
  output byte_t      sh_tx_o,
  input  logic       sh_done_i,
  input  byte_t      sh_rx_i
);
  seq_st_e st_q;
  kind_e   kind_q;
  op_e     op_q;
  byte_t   addr_q, wlen_q, rmax_q, rem_q, rcnt_q, rd_data_q, clip;
  logic    csn_q, done_q, rd_valid_q, accept;
  byte_t   cmd_code;
  logic    is_reg;

  assign accept = (st_q == S_IDLE) && start_i && (op_i <= 3'd5);

  // read count after the length byte: L + 1 (quality byte), clipped to limit
  always_comb begin
    if (({1'b0, sh_rx_i} + 9'd1) > {1'b0, rmax_q}) clip = rmax_q;
    else                                            clip = sh_rx_i + 8'd1;
  end

  always_comb begin
    is_reg = 1'b0;
    unique case (op_q)
      OP_REG_WR:  begin cmd_code = CMD_REG_WR; is_reg = 1'b1; end
      OP_REG_RD:  begin cmd_code = CMD_REG_RD; is_reg = 1'b1; end
      OP_BUF_WR:  cmd_code = CMD_BUF_WR;
      OP_BUF_RD:  cmd_code = CMD_BUF_RD;
      OP_SRAM_WR: cmd_code = CMD_SRAM_WR;
      default:    cmd_code = CMD_SRAM_RD;
    endcase
  end

  always_comb begin
    unique case (kind_q)
      K_CMD:   sh_tx_o = cmd_code | (is_reg ? (addr_q & REG_IDX_MASK) : 8'h00);
      K_ADDR:  sh_tx_o = addr_q;
      K_LEN:   sh_tx_o = wlen_q;
      K_WDATA: sh_tx_o = wr_data_i;
      default: sh_tx_o = 8'h00;
    endcase
  end

  assign wr_ready_o = (st_q == S_LOAD) && (kind_q == K_WDATA);
  assign sh_go_o    = (st_q == S_LOAD) && ((kind_q != K_WDATA) || wr_valid_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      kind_q     <= K_CMD;
      op_q       <= OP_REG_WR;
      addr_q     <= '0;
      wlen_q     <= '0;
      rmax_q     <= '0;
      rem_q      <= '0;
      rcnt_q     <= '0;
      rd_data_q  <= '0;
      csn_q      <= 1'b1;
      done_q     <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      done_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (accept) begin
          op_q   <= op_e'(op_i);
          addr_q <= addr_i;
          wlen_q <= wr_len_i;
          rmax_q <= rd_max_i;
          rcnt_q <= '0;
          csn_q  <= 1'b0;
          st_q   <= S_SEL;
        end
        S_SEL: begin
          kind_q <= K_CMD;
          st_q   <= S_LOAD;
        end
        S_LOAD: if (sh_go_o) st_q <= S_XFER;
        S_XFER: if (sh_done_i) begin
          st_q <= S_LOAD;
          unique case (kind_q)
            K_CMD: begin
              unique case (op_q)
                OP_REG_WR: begin kind_q <= K_WDATA; rem_q <= 8'd1; end
                OP_REG_RD: begin kind_q <= K_RDATA; rem_q <= 8'd1; end
                OP_BUF_WR: kind_q <= K_LEN;
                OP_BUF_RD: kind_q <= K_RLEN;
                default:   kind_q <= K_ADDR;
              endcase
            end
            K_ADDR: begin
              rem_q  <= 8'd1;
              kind_q <= (op_q == OP_SRAM_WR) ? K_WDATA : K_RDATA;
            end
            K_LEN: begin
              rem_q  <= wlen_q;
              kind_q <= K_WDATA;
              if (wlen_q == 8'd0) st_q <= S_END;
            end
            K_RLEN: begin
              rem_q  <= clip;
              kind_q <= K_RDATA;
              if (clip == 8'd0) st_q <= S_END;
            end
            K_RDATA: begin
              rd_valid_q <= 1'b1;
              rd_data_q  <= sh_rx_i;
              rcnt_q     <= rcnt_q + 8'd1;
              rem_q      <= rem_q - 8'd1;
              if (rem_q == 8'd1) st_q <= S_END;
            end
            default: begin
              rem_q <= rem_q - 8'd1;
              if (rem_q == 8'd1) st_q <= S_END;
            end
          endcase
        end
        default: begin
          csn_q  <= 1'b1;
          done_q <= 1'b1;
          st_q   <= S_IDLE;
        end
      endcase
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;
  assign rd_len_o   = rcnt_q;
  assign done_o     = done_q;
  assign busy_o     = (st_q != S_IDLE);
  assign csn_o      = csn_q;

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  p_clip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && op_q == OP_BUF_RD) |-> (rcnt_q <= rmax_q));

  p_restart_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != S_IDLE && start_i) |=> ($stable(op_q) && $stable(addr_q) && $stable(wlen_q)));

  p_stream_only_when_xfer_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_q |-> !csn_q);
endmodule

// File: rtl/rf_spi_engine.sv
module rf_spi_engine
  import rf_spi_pkg::*;
#(
  parameter int unsigned HALF_DIV     = 2,
  parameter byte_t       CMD_REG_WR   = 8'hC0,
  parameter byte_t       CMD_REG_RD   = 8'h80,
  parameter byte_t       CMD_BUF_WR   = 8'h60,
  parameter byte_t       CMD_BUF_RD   = 8'h20,
  parameter byte_t       CMD_SRAM_WR  = 8'h40,
  parameter byte_t       CMD_SRAM_RD  = 8'h00,
  parameter byte_t       REG_IDX_MASK = 8'h3F
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [2:0] op_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wr_len_i,
  input  logic [7:0] rd_max_i,
  input  logic       wr_valid_i,
  input  logic [7:0] wr_data_i,
  output logic       wr_ready_o,
  output logic       rd_valid_o,
  output logic [7:0] rd_data_o,
  output logic [7:0] rd_len_o,
  output logic       done_o,
  output logic       busy_o,
  output logic       spi_csn_o,
  output logic       spi_sck_o,
  output logic       spi_mosi_o,
  input  logic       spi_miso_i
);
  logic  sh_go, sh_done, sh_busy;
  byte_t sh_tx, sh_rx;

  rf_cmd_seq #(
    .CMD_REG_WR   (CMD_REG_WR),
    .CMD_REG_RD   (CMD_REG_RD),
    .CMD_BUF_WR   (CMD_BUF_WR),
    .CMD_BUF_RD   (CMD_BUF_RD),
    .CMD_SRAM_WR  (CMD_SRAM_WR),
    .CMD_SRAM_RD  (CMD_SRAM_RD),
    .REG_IDX_MASK (REG_IDX_MASK)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .op_i       (op_i),
    .addr_i     (addr_i),
    .wr_len_i   (wr_len_i),
    .rd_max_i   (rd_max_i),
    .wr_valid_i (wr_valid_i),
    .wr_data_i  (wr_data_i),
    .wr_ready_o (wr_ready_o),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o),
    .rd_len_o   (rd_len_o),
    .done_o     (done_o),
    .busy_o     (busy_o),
    .csn_o      (spi_csn_o),
    .sh_go_o    (sh_go),
    .sh_tx_o    (sh_tx),
    .sh_done_i  (sh_done),
    .sh_rx_i    (sh_rx)
  );

  rf_spi_shifter #(.HALF(HALF_DIV)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (sh_go),
    .tx_i   (sh_tx),
    .miso_i (spi_miso_i),
    .sck_o  (spi_sck_o),
    .mosi_o (spi_mosi_o),
    .busy_o (sh_busy),
    .done_o (sh_done),
    .rx_o   (sh_rx)
  );

  p_shift_inside_frame_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_busy |-> !spi_csn_o);

  p_no_clock_deselected_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_csn_o |-> !spi_sck_o);

  p_stall_holds_clock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ready_o && !wr_valid_i) |-> (!spi_sck_o && !sh_busy));

  p_idle_not_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && spi_csn_o));
endmodule

// File: tb/rf_spi_engine_tb.sv
module rf_spi_engine_tb;
  localparam int HALF = 2;
  localparam logic [7:0] C_RW = 8'hC0, C_RR = 8'h80, C_BW = 8'h60,
                         C_BR = 8'h20, C_SW = 8'h40, C_SR = 8'h00;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wvalid = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] addr = '0, wlen = '0, rmax = '0, wdata = '0;
  wire wready, rvalid, done, busy, csn, sck, mosi, miso;
  wire [7:0] rdata, rlen;

  int checks = 0, errors = 0, sel_cnt = 0;
  string cur_tag = "R1";
  logic [7:0] exp_mosi[$];
  logic [7:0] exp_rd[$];
  logic [7:0] resp[0:511];
  logic [7:0] wbuf[0:255];
  logic [8:0] byte_cnt = '0;
  logic [3:0] bit_cnt = '0;
  logic [7:0] sh_in = '0;

  always #2.5 clk = ~clk;

  rf_spi_engine #(.HALF_DIV(HALF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .addr_i(addr),
    .wr_len_i(wlen), .rd_max_i(rmax), .wr_valid_i(wvalid), .wr_data_i(wdata),
    .wr_ready_o(wready), .rd_valid_o(rvalid), .rd_data_o(rdata), .rd_len_o(rlen),
    .done_o(done), .busy_o(busy), .spi_csn_o(csn), .spi_sck_o(sck),
    .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // slave model: updates its output just after each rising edge (R3)
  assign miso = resp[byte_cnt][3'd7 - bit_cnt[2:0]];

  always @(negedge csn) begin
    bit_cnt  = '0;
    byte_cnt = '0;
    sel_cnt++;
  end

  always @(posedge sck) begin
    if (!csn) begin
      sh_in   = {sh_in[6:0], mosi};
      bit_cnt = bit_cnt + 4'd1;
      if (bit_cnt == 4'd8) begin
        bit_cnt  = '0;
        byte_cnt = byte_cnt + 9'd1;
        if (exp_mosi.size() == 0) check(1'b0, cur_tag, "unexpected mosi byte", int'(sh_in), -1);
        else begin
          automatic logic [7:0] e = exp_mosi.pop_front();
          check(sh_in == e, cur_tag, "mosi byte (R2 msb first)", int'(sh_in), int'(e));
        end
      end
    end else check(1'b0, "R1", "sck pulse while deselected", 1, 0);
  end

  // read stream monitor (scoreboard)
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_rd.size() == 0) check(1'b0, cur_tag, "unexpected read byte", int'(rdata), -1);
      else begin
        automatic logic [7:0] e = exp_rd.pop_front();
        check(rdata == e, cur_tag, "read byte (R3 sample point)", int'(rdata), int'(e));
      end
    end
  end

  // clock width and data-out stability
  int hi_w = 0;
  logic prev_sck = 1'b0, prev_mosi = 1'b0;
  always @(negedge clk) begin
    if (sck) hi_w++;
    else if (hi_w != 0) begin
      check(hi_w == HALF, "R10", "sck high width", hi_w, HALF);
      hi_w = 0;
    end
    if (sck && prev_sck && mosi != prev_mosi)
      check(1'b0, "R2", "mosi changed while sck high", int'(mosi), int'(prev_mosi));
    prev_sck  = sck;
    prev_mosi = mosi;
  end

  task automatic feed(input int n, input int stall);
    for (int i = 0; i < n; i++) begin
      wvalid = 1'b0;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        if (wready) check(!sck && bit_cnt == 4'd0, "R9", "sck held low during stall", int'(sck), 0);
      end
      @(negedge clk);
      wdata  = wbuf[i];
      wvalid = 1'b1;
      while (!wready) @(negedge clk);
      @(posedge clk);
      #1 wvalid = 1'b0;
    end
  endtask

  task automatic await_done(input bit inject);
    int k = 0;
    while (!done) begin
      @(negedge clk);
      k++;
      if (inject && k == 20) begin start = 1'b1; op = 3'd5; addr = 8'h77; end
      else start = 1'b0;
    end
    start = 1'b0;
  endtask

  task automatic run_txn(input logic [2:0] o, input logic [7:0] a, input logic [7:0] wl,
                         input logic [7:0] rm, input logic [7:0] blen, input int stall,
                         input bit inject, input string tag);
    int nrd = 0, nwr = 0, n, sel0;
    for (int i = 0; i < 512; i++) resp[i] = 8'(i * 37 + 11);
    for (int i = 0; i < 256; i++) wbuf[i] = 8'(i * 91 + int'(a) + 5);
    exp_mosi.delete();
    exp_rd.delete();
    cur_tag = tag;
    case (o)
      3'd0: begin exp_mosi.push_back(C_RW | (a & 8'h3F)); exp_mosi.push_back(wbuf[0]); nwr = 1; end
      3'd1: begin
        exp_mosi.push_back(C_RR | (a & 8'h3F)); exp_mosi.push_back(8'h00);
        exp_rd.push_back(resp[1]); nrd = 1;
      end
      3'd2: begin
        exp_mosi.push_back(C_BW); exp_mosi.push_back(wl);
        for (int i = 0; i < int'(wl); i++) exp_mosi.push_back(wbuf[i]);
        nwr = int'(wl);
      end
      3'd3: begin
        resp[1] = blen;
        n = (int'(blen) + 1 > int'(rm)) ? int'(rm) : int'(blen) + 1;
        exp_mosi.push_back(C_BR); exp_mosi.push_back(8'h00);
        for (int i = 0; i < n; i++) begin exp_mosi.push_back(8'h00); exp_rd.push_back(resp[i + 2]); end
        nrd = n;
      end
      3'd4: begin exp_mosi.push_back(C_SW); exp_mosi.push_back(a); exp_mosi.push_back(wbuf[0]); nwr = 1; end
      default: begin
        exp_mosi.push_back(C_SR); exp_mosi.push_back(a); exp_mosi.push_back(8'h00);
        exp_rd.push_back(resp[2]); nrd = 1;
      end
    endcase
    sel0 = sel_cnt;
    @(negedge clk);
    op = o; addr = a; wlen = wl; rmax = rm; start = 1'b1;
    @(negedge clk);
    start = 1'b0; op = 3'd1; addr = 8'hE5; wlen = 8'd9;
    fork
      feed(nwr, stall);
      await_done(inject);
    join
    check(csn == 1'b1, "R1", "csn high at done", int'(csn), 1);
    check(busy == 1'b0, "R11", "busy low at done", int'(busy), 0);
    check(int'(rlen) == nrd, tag, "read length", int'(rlen), nrd);
    @(negedge clk);
    check(done == 1'b0, "R11", "done is one cycle", int'(done), 0);
    check(int'(rlen) == nrd, "R11", "read length held", int'(rlen), nrd);
    check(exp_mosi.size() == 0, tag, "mosi bytes left over", exp_mosi.size(), 0);
    check(exp_rd.size() == 0, tag, "read bytes left over", exp_rd.size(), 0);
    check(sel_cnt == sel0 + 1, inject ? "R8" : "R1", "select windows", sel_cnt - sel0, 1);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R11", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(csn == 1'b1, "R1", "reset csn", int'(csn), 1);
    check(sck == 1'b0, "R2", "reset sck", int'(sck), 0);
    check(busy == 1'b0 && done == 1'b0, "R11", "reset busy/done", int'({busy, done}), 0);
    check(wready == 1'b0, "R9", "reset ready", int'(wready), 0);

    run_txn(3'd0, 8'h15, 8'd0, 8'd0, 8'd0, 0, 1'b0, "R4");
    run_txn(3'd0, 8'hFF, 8'd0, 8'd0, 8'd0, 3, 1'b0, "R4");
    run_txn(3'd1, 8'h07, 8'd0, 8'd0, 8'd0, 0, 1'b0, "R4");
    run_txn(3'd1, 8'hC9, 8'd0, 8'd0, 8'd0, 0, 1'b0, "R3");
    run_txn(3'd2, 8'h00, 8'd4, 8'd0, 8'd0, 2, 1'b0, "R5");
    run_txn(3'd2, 8'h00, 8'd0, 8'd0, 8'd0, 0, 1'b0, "R5");
    run_txn(3'd3, 8'h00, 8'd0, 8'd10, 8'd3, 0, 1'b0, "R6");
    run_txn(3'd3, 8'h00, 8'd0, 8'd5, 8'd9, 0, 1'b0, "R6");
    run_txn(3'd3, 8'h00, 8'd0, 8'd255, 8'd255, 0, 1'b0, "R6");
    run_txn(3'd3, 8'h00, 8'd0, 8'd0, 8'd4, 0, 1'b0, "R6");
    run_txn(3'd4, 8'h80, 8'd0, 8'd0, 8'd0, 1, 1'b0, "R7");
    run_txn(3'd5, 8'h3F, 8'd0, 8'd0, 8'd0, 0, 1'b0, "R7");
    run_txn(3'd2, 8'h00, 8'd3, 8'd0, 8'd0, 4, 1'b1, "R8");

    // R8: op codes 6 and 7 are ignored
    for (int v = 6; v < 8; v++) begin
      automatic int sel0 = sel_cnt;
      @(negedge clk);
      op = 3'(v); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (40) @(negedge clk);
      check(busy == 1'b0 && csn == 1'b1, "R8", "invalid op ignored", int'({busy, csn}), 1);
      check(sel_cnt == sel0, "R8", "no select for invalid op", sel_cnt - sel0, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule